// File: doc/BRIEF.md
# Real-Time Clock Register File with Periodic Interrupt

This block is the host-facing byte register file of a real-time clock. A small address space holds ten time-of-day bytes at the bottom. Above them sit four status and control bytes. Control byte A holds a time-base divider select, an interrupt rate select and a read-only update-in-progress flag. Control byte B holds the mode bits. Status bytes C and D always read as zero. Time counting, alarm matching and update-ended events belong to other blocks. This block only stores the time bytes and presents them to the host.

The host uses a single address bus with separate read and write strobes. Read data is registered and appears one cycle after the read strobe. The block also counts a 32.768 kHz enable strobe. From that count it produces a one-cycle periodic interrupt pulse at the rate set in control byte A, while the periodic enable in control byte B is set.

Top module: `rtc_regfile`

## Requirements
- R1: Addresses 0x00 to 0x09 are plain read/write storage bytes for the time-of-day fields. All of them are zero after reset.
- R2: `bus_rdata` is updated on the clock edge where `bus_rd` is sampled high. Addresses above 0x0D read as 0x00, and a write to them changes no state.
- R3: Control byte A is at 0x0A. Bit 7 is the update-in-progress flag, bits [6:4] are the divider select and bits [3:0] are the rate select. The reset value is flag 0, divider 3'b010 and rate 4'b0110.
- R4: A write to 0x0A updates the divider and rate fields only. The update-in-progress flag keeps the value it had before the write.
- R5: Each read of 0x0A first inverts the update-in-progress flag and then returns the byte with the inverted flag. After reset, the first read returns 0xA6 and the second returns 0x26.
- R6: Status bytes C (0x0C) and D (0x0D) always read 0x00, and writes to them are ignored.
- R7: Control byte B is at 0x0B. Bit 6 is the periodic enable, bit 2 is the data mode and bit 1 is 24-hour format. At reset it is 0x42, with bit 2 taken from `bin_mode_cfg`. It is 0x46 when `bin_mode_cfg` is 1.
- R8: A write to 0x0B stores all eight bits, and they read back unchanged.
- R9: While the periodic interrupt runs at the default rate, `pirq` pulses high for exactly one cycle on the edge after every 32nd `tick_32k` strobe. The first pulse follows the 32nd strobe after reset.
- R10: Writing byte B with bit 6 = 0 stops the pulses and clears the strobe count. Writing bit 6 = 1 while the interrupt is already running does not restart the count. Writing bit 6 = 1 while it is stopped starts a fresh count.
- R11: The rate select sets the strobes per pulse. Rate 0 gives no pulses, rate 1 gives 128, rate 2 gives 256, and rates 3 to 15 give 2^(rate-1). Any write to byte A restarts the count.
- R12: Divider select 3'b110 or 3'b111 halts the periodic count. Every other divider value lets it run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bin_mode_cfg | input | 1 | Reset value of the data mode bit in byte B |
| tick_32k | input | 1 | 32.768 kHz enable strobe, one cycle wide |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pirq | output | 1 | Periodic interrupt pulse |

## Verification
The assertions check on every cycle that:
- the update-in-progress flag flips on each read of byte A and holds across writes to it;
- status reads and out-of-range reads return zero;
- each interrupt pulse is one cycle wide and follows a strobe;
- a periodic-enable clear silences the output.

Only the bench scenarios can show the pulse spacing for each rate and the fact that re-enabling a running interrupt does not restart its count. The same holds for the reset value of the data-mode bit from the configuration pin, and for storage readback across the time bytes.

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bin_mode_cfg,
  input  logic              tick_32k,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              pirq
);
  localparam int NUM_TIME = 10;
  localparam logic [ADDR_W-1:0] A_CTLA = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_CTLB = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] A_STC  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_STD  = ADDR_W'(13);
  localparam logic [2:0] DIV_RST  = 3'b010;
  localparam logic [3:0] RATE_RST = 4'b0110;

  logic [7:0]       time_q [NUM_TIME];
  logic             uip_q;
  logic [2:0]       div_q;
  logic [3:0]       rate_q;
  logic [7:0]       ctlb_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pirq_q;
  logic [7:0]       rdata_q;

  function automatic logic [CNT_W-1:0] last_of(input logic [3:0] rs);
    case (rs)
      4'd1:    last_of = CNT_W'(127);
      4'd2:    last_of = CNT_W'(255);
      default: last_of = CNT_W'((32'd1 << (rs - 4'd1)) - 32'd1);
    endcase
  endfunction

  wire              hit_time = bus_addr < ADDR_W'(NUM_TIME);
  wire [3:0]        tidx     = bus_addr[3:0];
  wire              wr_a     = bus_wr && bus_addr == A_CTLA;
  wire              wr_b     = bus_wr && bus_addr == A_CTLB;
  wire              div_halt = div_q[2:1] == 2'b11;
  wire              running  = ctlb_q[6] && rate_q != 4'd0 && !div_halt;
  wire [CNT_W-1:0]  last     = last_of(rate_q);
  wire              wrap     = running && !wr_a && tick_32k && cnt_q == last;

  assign bus_rdata = rdata_q;
  assign pirq      = pirq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TIME; i++) time_q[i] <= 8'h00;
    end else if (bus_wr && hit_time) begin
      time_q[tidx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uip_q  <= 1'b0;
      div_q  <= DIV_RST;
      rate_q <= RATE_RST;
      ctlb_q <= {5'b01000, bin_mode_cfg, 2'b10};
    end else begin
      if (bus_rd && bus_addr == A_CTLA) uip_q <= ~uip_q;
      if (wr_a) begin
        div_q  <= bus_wdata[6:4];
        rate_q <= bus_wdata[3:0];
      end
      if (wr_b) ctlb_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= 8'h00;
    end else if (bus_rd) begin
      if (hit_time)                rdata_q <= time_q[tidx];
      else if (bus_addr == A_CTLA) rdata_q <= {~uip_q, div_q, rate_q};
      else if (bus_addr == A_CTLB) rdata_q <= ctlb_q;
      else                         rdata_q <= 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pirq_q <= 1'b0;
    end else begin
      pirq_q <= wrap;
      if (!running || wr_a)  cnt_q <= '0;
      else if (wrap)         cnt_q <= '0;
      else if (tick_32k)     cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r5_uip_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_CTLA) |=> (uip_q != $past(uip_q)));

  a_r4_uip_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !bus_rd) |=> (uip_q == $past(uip_q)));

  a_r6_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == A_STC || bus_addr == A_STD)) |=> (bus_rdata == 8'h00));

  a_r2_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr > A_STD) |=> (bus_rdata == 8'h00));

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pirq |=> !pirq);

  a_r9_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pirq) |-> $past(tick_32k));

  a_r10_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && !bus_wdata[6]) |=> ##1 !pirq);
endmodule

// File: tb/rtc_regfile_tb_top.sv
module rtc_regfile_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bin_mode_cfg = 1'b0;
  logic       tick_32k = 1'b0;
  logic [6:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       pirq;

  int checks = 0;
  int fails = 0;
  int pulses = 0;

  always #5 clk = ~clk;

  rtc_regfile #(.ADDR_W(7), .CNT_W(15)) dut_i (
    .clk(clk), .rst_n(rst_n), .bin_mode_cfg(bin_mode_cfg), .tick_32k(tick_32k),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .pirq(pirq)
  );

  always @(posedge clk) if (rst_n && pirq) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic cfg);
    @(negedge clk);
    rst_n = 1'b0;
    bin_mode_cfg = cfg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_32k = 1'b1;
      @(negedge clk); tick_32k = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [7:0] d;
    rd(7'h0A, d); chk("R3/R5 first A read", d, 8'hA6);
    rd(7'h0A, d); chk("R5 second A read", d, 8'h26);
    rd(7'h0B, d); chk("R7 B reset cfg=0", d, 8'h42);
    rd(7'h0C, d); chk("R6 C reads zero", d, 8'h00);
    rd(7'h0D, d); chk("R6 D reads zero", d, 8'h00);
    rd(7'h05, d); chk("R1 time byte reset", d, 8'h00);
  endtask

  task automatic t_time_bytes;
    logic [7:0] d;
    for (int i = 0; i < 10; i++) wr(7'(i), 8'(i * 17 + 3));
    for (int i = 0; i < 10; i++) begin
      rd(7'(i), d); chk("R1 time byte readback", d, i * 17 + 3);
    end
    wr(7'h20, 8'h5A);
    rd(7'h20, d); chk("R2 out-of-range reads zero", d, 8'h00);
    rd(7'h00, d); chk("R2 out-of-range write ignored", d, 8'h03);
    wr(7'h0C, 8'hFF);
    rd(7'h0C, d); chk("R6 C write ignored", d, 8'h00);
  endtask

  task automatic t_ctl_writes;
    logic [7:0] d;
    wr(7'h0A, 8'hA6);
    rd(7'h0A, d); chk("R4 A write keeps uip 0", d, 8'hA6);
    wr(7'h0A, 8'h26);
    rd(7'h0A, d); chk("R4 A write keeps uip 1", d, 8'h26);
    wr(7'h0B, 8'h3F);
    rd(7'h0B, d); chk("R8 B readback", d, 8'h3F);
    wr(7'h0B, 8'h42);
    rd(7'h0B, d); chk("R8 B readback 2", d, 8'h42);
  endtask

  task automatic t_default_rate;
    wr(7'h0A, 8'h26);
    pulses = 0; strobes(31); chk("R9 no pulse before 32", pulses, 0);
    strobes(1);  chk("R9 pulse at 32", pulses, 1);
    pulses = 0; strobes(64); chk("R9 two periods", pulses, 2);
  endtask

  task automatic t_enable_ctl;
    pulses = 0; strobes(20);
    wr(7'h0B, 8'h42);
    strobes(11); chk("R10 re-enable keeps count", pulses, 0);
    strobes(1);  chk("R10 pulse on original schedule", pulses, 1);
    strobes(10);
    wr(7'h0B, 8'h02);
    pulses = 0; strobes(40); chk("R10 disabled no pulses", pulses, 0);
    wr(7'h0B, 8'h42);
    strobes(31); chk("R10 fresh count after enable", pulses, 0);
    strobes(1);  chk("R10 first pulse after enable", pulses, 1);
  endtask

  task automatic t_rates;
    wr(7'h0A, 8'h23);
    pulses = 0; strobes(16); chk("R11 rate 3 period 4", pulses, 4);
    wr(7'h0A, 8'h21);
    pulses = 0; strobes(127); chk("R11 rate 1 before 128", pulses, 0);
    strobes(1); chk("R11 rate 1 at 128", pulses, 1);
    wr(7'h0A, 8'h20);
    pulses = 0; strobes(100); chk("R11 rate 0 silent", pulses, 0);
  endtask

  task automatic t_divider;
    wr(7'h0A, 8'h63);
    pulses = 0; strobes(40); chk("R12 divider 110 halts", pulses, 0);
    wr(7'h0A, 8'h73);
    strobes(40); chk("R12 divider 111 halts", pulses, 0);
    wr(7'h0A, 8'h53);
    strobes(4); chk("R12 divider 101 runs", pulses, 1);
  endtask

  task automatic t_bin_cfg;
    logic [7:0] d;
    do_reset(1'b1);
    rd(7'h0B, d); chk("R7 B reset cfg=1", d, 8'h46);
    rd(7'h0A, d); chk("R3 A reset after second reset", d, 8'hA6);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    t_reset_state();
    t_time_bytes();
    t_ctl_writes();
    t_default_rate();
    t_enable_ctl();
    t_rates();
    t_divider();
    t_bin_cfg();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule